// File: doc/BRIEF.md
# Multi-Page-Size Data Translation Buffer

This block turns the virtual address of a load or store into a physical address. It holds a small set of fully associative entries, and each entry records its own page size. The size sets how many low virtual-address bits an entry ignores when it compares, and how many physical-address bits pass straight through from the virtual address. A lookup finishes in the cycle it is accepted and gives one of three results: a hit with a physical address, a miss, or a protection fault. On a miss or a fault the pipeline traps to privileged software. That software then loads a new entry through the fill port, which picks the slot in round-robin order.

The lookup and fill ports use valid/ready handshakes. The block lowers both ready signals only in a cycle where the invalidate-all control is high, and in that cycle it takes no request. The result side has no back-pressure: `res_valid` goes high combinationally in every cycle where a lookup is accepted, and the consumer must take the result in that cycle. An invalidate-all pulse marks every entry empty at the next clock edge.

Top module: `data_xlate_buf`

## Requirements
- R1: After reset every entry is empty, so every lookup gives a miss, and the fill pointer is at slot 0.
- R2: `lk_ready` and `fill_ready` are high exactly when `inv_all` is low. `res_valid` equals `lk_valid && lk_ready` in the same cycle. While `res_valid` is high, exactly one of `res_hit`, `res_miss`, `res_fault` is high; otherwise all three are low.
- R3: The size code of an entry sets the page offset width: 2'b00 gives 13 bits (8KB), 2'b01 gives 16 (64KB), 2'b10 gives 19 (512KB), 2'b11 gives 22 (4MB). Virtual bits below that width play no part in the compare.
- R4: On a hit, `res_pa` bits below the entry's offset width come from `lk_va`, and the bits above it come from the entry's stored frame. The frame is held as `fill_pfn`, which supplies physical bits 33:13. `res_pa` is zero whenever `res_hit` is low.
- R5: `lk_write`=1 marks a store, which needs the entry's write permission. `lk_write`=0 marks a load, which needs read permission. If the matched entry lacks the needed permission, the result is a fault and `res_hit` is low.
- R6: If several valid entries match, the lowest-numbered one decides the address and the permission outcome.
- R7: An accepted fill writes slot `ptr`, marks it valid, and moves `ptr` to `ptr+1` modulo 32. The new entry takes effect at the clock edge, so a lookup in the same cycle still sees the old contents.
- R8: `inv_all` empties every entry at the next clock edge and leaves the fill pointer unchanged.
- R9: A virtual address just past the end of a mapped page, that is the page base plus the page size, gives a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inv_all | input | 1 | Empty all entries at the next edge |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_va | input | 43 | Virtual address to translate |
| lk_write | input | 1 | 1 = store, 0 = load |
| res_valid | output | 1 | Result present this cycle |
| res_hit | output | 1 | Translation succeeded |
| res_miss | output | 1 | No valid entry matched |
| res_fault | output | 1 | Matched entry denies the access |
| res_pa | output | 34 | Physical address on a hit |
| fill_valid | input | 1 | Fill request present |
| fill_ready | output | 1 | Fill can be accepted |
| fill_vpn | input | 30 | Virtual page bits 42:13 |
| fill_pfn | input | 21 | Physical frame bits 33:13 |
| fill_size | input | 2 | Page size code |
| fill_rd_ok | input | 1 | Load permitted |
| fill_wr_ok | input | 1 | Store permitted |

## Verification
The case to watch is a fill and a lookup in the same cycle for the same virtual page. The bench raises both handshakes together on a new address. It expects a miss in that cycle, because the entry is only written at the edge, and a hit with the new frame one cycle later. A second such case raises `inv_all` together with a fill and a lookup. The bench expects both readies low, no result, an unchanged fill pointer, and misses everywhere afterwards.

// File: rtl/dxb_pkg.sv
package dxb_pkg;
  localparam int DXB_ENTRIES    = 32;
  localparam int DXB_VA_W       = 43;
  localparam int DXB_PA_W       = 34;
  localparam int DXB_BASE_SHIFT = 13;
  localparam int DXB_SHIFT_STEP = 3;

  typedef enum logic [1:0] {
    PG_8K   = 2'b00,
    PG_64K  = 2'b01,
    PG_512K = 2'b10,
    PG_4M   = 2'b11
  } pgsz_e;

  // extra offset bits above the smallest page for a size code
  function automatic int extra_bits(pgsz_e sz, int step);
    return step * int'(sz);
  endfunction
endpackage

// File: rtl/dxb_entry.sv
module dxb_entry
  import dxb_pkg::*;
#(
  parameter int VA_W       = DXB_VA_W,
  parameter int PA_W       = DXB_PA_W,
  parameter int BASE_SHIFT = DXB_BASE_SHIFT,
  parameter int SHIFT_STEP = DXB_SHIFT_STEP
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       wr_en,
  input  logic [VA_W-BASE_SHIFT-1:0] wr_tag,
  input  logic [PA_W-BASE_SHIFT-1:0] wr_frame,
  input  pgsz_e                      wr_size,
  input  logic                       wr_rd,
  input  logic                       wr_wr,
  input  logic [VA_W-1:0]            lk_va,
  output logic                       match,
  output logic                       rd_ok,
  output logic                       wr_ok,
  output logic [PA_W-1:0]            pa
);
  localparam int TAG_W = VA_W - BASE_SHIFT;
  localparam int FRM_W = PA_W - BASE_SHIFT;

  logic             valid_q;
  logic [TAG_W-1:0] tag_q;
  logic [FRM_W-1:0] frm_q;
  pgsz_e            size_q;
  logic             rd_q;
  logic             wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      frm_q   <= '0;
      size_q  <= PG_8K;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else if (clr) begin
      valid_q <= 1'b0;
    end else if (wr_en) begin
      valid_q <= 1'b1;
      tag_q   <= wr_tag;
      frm_q   <= wr_frame;
      size_q  <= wr_size;
      rd_q    <= wr_rd;
      wr_q    <= wr_wr;
    end
  end

  int               low_bits;
  logic             differs;
  logic [FRM_W-1:0] pa_hi;

  always_comb begin
    low_bits = extra_bits(size_q, SHIFT_STEP);
    differs  = 1'b0;
    for (int i = 0; i < TAG_W; i++) begin
      if (i >= low_bits && tag_q[i] != lk_va[BASE_SHIFT+i]) differs = 1'b1;
    end
    for (int k = 0; k < FRM_W; k++) begin
      pa_hi[k] = (k < low_bits) ? lk_va[BASE_SHIFT+k] : frm_q[k];
    end
  end

  assign match = valid_q && !differs;
  assign rd_ok = rd_q;
  assign wr_ok = wr_q;
  assign pa    = {pa_hi, lk_va[BASE_SHIFT-1:0]};
endmodule

// File: rtl/dxb_pick.sv
module dxb_pick #(
  parameter int N    = 32,
  parameter int PA_W = 34
) (
  input  logic [N-1:0]           match,
  input  logic [N-1:0]           rd_ok,
  input  logic [N-1:0]           wr_ok,
  input  logic [N-1:0][PA_W-1:0] pa,
  output logic                   any,
  output logic                   sel_rd,
  output logic                   sel_wr,
  output logic [PA_W-1:0]        sel_pa
);
  // scan downward so the lowest matching index is the last to write
  always_comb begin
    any    = 1'b0;
    sel_rd = 1'b0;
    sel_wr = 1'b0;
    sel_pa = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        any    = 1'b1;
        sel_rd = rd_ok[i];
        sel_wr = wr_ok[i];
        sel_pa = pa[i];
      end
    end
  end
endmodule

// File: rtl/dxb_rr_ptr.sv
module dxb_rr_ptr #(
  parameter int N     = 32,
  parameter int PTR_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(N - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr <= '0;
    else if (adv)      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/data_xlate_buf.sv
module data_xlate_buf
  import dxb_pkg::*;
#(
  parameter int ENTRIES    = DXB_ENTRIES,
  parameter int VA_W       = DXB_VA_W,
  parameter int PA_W       = DXB_PA_W,
  parameter int BASE_SHIFT = DXB_BASE_SHIFT,
  parameter int SHIFT_STEP = DXB_SHIFT_STEP
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       inv_all,
  input  logic                       lk_valid,
  output logic                       lk_ready,
  input  logic [VA_W-1:0]            lk_va,
  input  logic                       lk_write,
  output logic                       res_valid,
  output logic                       res_hit,
  output logic                       res_miss,
  output logic                       res_fault,
  output logic [PA_W-1:0]            res_pa,
  input  logic                       fill_valid,
  output logic                       fill_ready,
  input  logic [VA_W-BASE_SHIFT-1:0] fill_vpn,
  input  logic [PA_W-BASE_SHIFT-1:0] fill_pfn,
  input  logic [1:0]                 fill_size,
  input  logic                       fill_rd_ok,
  input  logic                       fill_wr_ok
);
  localparam int PTR_W = $clog2(ENTRIES);

  logic [PTR_W-1:0]             fill_ptr;
  logic                         fill_fire;
  logic [ENTRIES-1:0]           e_match, e_rd, e_wr;
  logic [ENTRIES-1:0][PA_W-1:0] e_pa;
  logic                         any_match, sel_rd, sel_wr;
  logic [PA_W-1:0]              sel_pa;
  logic                         allowed;

  assign lk_ready   = !inv_all;
  assign fill_ready = !inv_all;
  assign fill_fire  = fill_valid && fill_ready;

  dxb_rr_ptr #(.N(ENTRIES), .PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv(fill_fire), .ptr(fill_ptr)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    dxb_entry #(
      .VA_W(VA_W), .PA_W(PA_W), .BASE_SHIFT(BASE_SHIFT), .SHIFT_STEP(SHIFT_STEP)
    ) u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (inv_all),
      .wr_en    (fill_fire && (fill_ptr == PTR_W'(g))),
      .wr_tag   (fill_vpn),
      .wr_frame (fill_pfn),
      .wr_size  (pgsz_e'(fill_size)),
      .wr_rd    (fill_rd_ok),
      .wr_wr    (fill_wr_ok),
      .lk_va    (lk_va),
      .match    (e_match[g]),
      .rd_ok    (e_rd[g]),
      .wr_ok    (e_wr[g]),
      .pa       (e_pa[g])
    );
  end

  dxb_pick #(.N(ENTRIES), .PA_W(PA_W)) u_pick (
    .match(e_match), .rd_ok(e_rd), .wr_ok(e_wr), .pa(e_pa),
    .any(any_match), .sel_rd(sel_rd), .sel_wr(sel_wr), .sel_pa(sel_pa)
  );

  assign allowed   = lk_write ? sel_wr : sel_rd;
  assign res_valid = lk_valid && lk_ready;
  assign res_hit   = res_valid && any_match && allowed;
  assign res_fault = res_valid && any_match && !allowed;
  assign res_miss  = res_valid && !any_match;
  assign res_pa    = res_hit ? sel_pa : '0;
endmodule

// File: rtl/dxb_checker.sv
module dxb_checker #(
  parameter int ENTRIES = 32,
  parameter int PTR_W   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inv_all,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic             fill_valid,
  input logic             fill_ready,
  input logic             res_valid,
  input logic             res_hit,
  input logic             res_miss,
  input logic             res_fault,
  input logic [12:0]      va_lo,
  input logic [12:0]      pa_lo,
  input logic [PTR_W-1:0] ptr
);
  AST_READY_TRACKS_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_ready == !inv_all) && (fill_ready == !inv_all)); // R2
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot({res_hit, res_miss, res_fault})); // R2
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !(res_hit || res_miss || res_fault)); // R2
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> (pa_lo == va_lo)); // R4
  AST_INV_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !(res_hit || res_fault)); // R8
  AST_INV_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> $stable(ptr)); // R8
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) |=>
      (ptr == (($past(ptr) == PTR_W'(ENTRIES - 1)) ? '0 : $past(ptr) + 1'b1))); // R7
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_valid && fill_ready) |=> $stable(ptr)); // R7
  AST_NO_RESULT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !res_valid); // R2
endmodule

bind data_xlate_buf dxb_checker #(.ENTRIES(ENTRIES), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
  .lk_valid(lk_valid), .lk_ready(lk_ready),
  .fill_valid(fill_valid), .fill_ready(fill_ready),
  .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss), .res_fault(res_fault),
  .va_lo(lk_va[12:0]), .pa_lo(res_pa[12:0]), .ptr(fill_ptr)
);

// File: tb/data_xlate_buf_tb.sv
`timescale 1ns/1ps
module data_xlate_buf_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inv_all = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [42:0] lk_va = '0;
  logic        lk_write = 1'b0;
  logic        res_valid, res_hit, res_miss, res_fault;
  logic [33:0] res_pa;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic [29:0] fill_vpn = '0;
  logic [20:0] fill_pfn = '0;
  logic [1:0]  fill_size = '0;
  logic        fill_rd_ok = 1'b0;
  logic        fill_wr_ok = 1'b0;

  always #2 clk = ~clk;

  data_xlate_buf u_dut (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench model of the stored entries
  logic [42:0] m_va [32];
  logic [33:0] m_pa [32];
  int          m_sz [32];
  bit          m_rd [32], m_wr [32], m_v [32];
  int          m_ptr = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected {hit,miss,fault} and pa from the requirements
  task automatic predict(logic [42:0] va, bit wr, output logic [2:0] o, output logic [33:0] pa);
    o = 3'b010; pa = '0;
    for (int i = 0; i < 32; i++) begin
      int sh;
      sh = 13 + 3 * m_sz[i];
      if (m_v[i] && ((64'(va) >> sh) == (64'(m_va[i]) >> sh))) begin
        if (wr ? m_wr[i] : m_rd[i]) begin
          logic [63:0] msk;
          msk = (64'd1 << sh) - 1;
          o  = 3'b100;
          pa = 34'((64'(m_pa[i]) & ~msk) | (64'(va) & msk));
        end else o = 3'b001;
        return;
      end
    end
  endtask

  task automatic lookup(string req, logic [42:0] va, bit wr);
    logic [2:0]  eo;
    logic [33:0] epa;
    @(negedge clk);
    lk_valid = 1'b1; lk_va = va; lk_write = wr;
    #1;
    predict(va, wr, eo, epa);
    check(req, {res_hit, res_miss, res_fault}, eo);
    check(req, res_pa, epa);
    lk_valid = 1'b0;
  endtask

  task automatic fill(logic [42:0] va, logic [33:0] pa, int sz, bit rd, bit wr);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = va[42:13]; fill_pfn = pa[33:13];
    fill_size = 2'(sz); fill_rd_ok = rd; fill_wr_ok = wr;
    @(posedge clk); #1;
    fill_valid = 1'b0;
    m_va[m_ptr] = va; m_pa[m_ptr] = pa; m_sz[m_ptr] = sz;
    m_rd[m_ptr] = rd; m_wr[m_ptr] = wr; m_v[m_ptr] = 1'b1;
    m_ptr = (m_ptr + 1) % 32;
  endtask

  function automatic logic [42:0] base_of(int i);
    return 43'(i + 1) << 25;
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      m_v[i] = 0; m_sz[i] = 0; m_rd[i] = 0; m_wr[i] = 0; m_va[i] = '0; m_pa[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: empty after reset, ready high
    check("R1", {lk_ready, fill_ready}, 2'b11);
    for (int i = 0; i < 4; i++) lookup("R1", base_of(i * 7), i[0]);

    // R2: no request, no result
    @(negedge clk); #1;
    check("R2", {res_valid, res_hit, res_miss, res_fault}, 4'b0000);

    // R3 R4 R5: fill every slot with mixed sizes and permissions
    for (int i = 0; i < 32; i++)
      fill(base_of(i), 34'(64'(i) * 64'h1234567 + 64'h2A000), i % 4, (i % 5) != 4, (i % 3) != 2);
    for (int i = 0; i < 32; i++) begin
      int sh;
      logic [42:0] off;
      sh  = 13 + 3 * (i % 4);
      off = 43'((64'(i) * 64'd40503 + 64'd7) % (64'd1 << sh));
      lookup("R3_R4_R5 load", base_of(i) | off, 1'b0);
      lookup("R3_R4_R5 store", base_of(i) | off, 1'b1);
      lookup("R3 top of page", base_of(i) | 43'((64'd1 << sh) - 1), 1'b0);
      // R9: one byte past the page end
      lookup("R9", base_of(i) + 43'(64'd1 << sh), 1'b0);
    end

    // R7: pointer wrapped, slot 0 replaced
    fill(43'h600_0000_0000, 34'h2_1234_0000, 0, 1'b1, 1'b0);
    lookup("R7 old gone", base_of(0), 1'b0);
    lookup("R7 new load", 43'h600_0000_0123, 1'b0);

    // R6: slot 1 maps the same page; slot 0 still decides
    fill(43'h600_0000_0000, 34'h3_0000_0000, 3, 1'b1, 1'b1);
    lookup("R6 load lowest", 43'h600_0000_0456, 1'b0);
    lookup("R6 store fault lowest", 43'h600_0000_0456, 1'b1);
    check("R6 fault flag", res_fault, 1'b1);

    // R7: fill and lookup together on one page
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = 30'h2AAAAAAA; fill_pfn = 21'h15555;
    fill_size = 2'd1; fill_rd_ok = 1'b1; fill_wr_ok = 1'b1;
    lk_valid = 1'b1; lk_va = {30'h2AAAAAAA, 13'h0ABC}; lk_write = 1'b0;
    #1;
    check("R7 same-cycle miss", {res_hit, res_miss, res_fault}, 3'b010);
    @(posedge clk); #1;
    fill_valid = 1'b0; lk_valid = 1'b0;
    m_va[m_ptr] = {30'h2AAAAAAA, 13'h0}; m_pa[m_ptr] = {21'h15555, 13'h0}; m_sz[m_ptr] = 1;
    m_rd[m_ptr] = 1; m_wr[m_ptr] = 1; m_v[m_ptr] = 1; m_ptr = (m_ptr + 1) % 32;
    lookup("R7 next-cycle hit", {30'h2AAAAAAA, 13'h0ABC}, 1'b0);

    // R8 with R2: invalidate beside a fill and a lookup
    @(negedge clk);
    inv_all = 1'b1; fill_valid = 1'b1; fill_vpn = 30'h1; lk_valid = 1'b1; lk_va = base_of(5);
    #1;
    check("R2 ready low", {lk_ready, fill_ready, res_valid}, 3'b000);
    @(posedge clk); #1;
    inv_all = 1'b0; fill_valid = 1'b0; lk_valid = 1'b0;
    for (int i = 0; i < 32; i++) m_v[i] = 0;
    for (int i = 0; i < 32; i++) lookup("R8 empty", base_of(i), 1'b0);
    lookup("R8 empty", 43'h600_0000_0000, 1'b1);
    // pointer unchanged: refill 29 slots then wrap onto slots 0.. again
    for (int i = 0; i < 30; i++) fill(base_of(i), 34'(i) << 22, 3, 1'b1, 1'b1);
    for (int i = 0; i < 30; i++) lookup("R8_R7 refill", base_of(i) | 43'h3F_FFFF, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule